// File: doc/BRIEF.md
# Serial EEPROM Chunked Access Sequencer

This block runs complete read and write requests against a serial EEPROM that takes a 16-bit address. It drives a byte-level SPI master. Software-free logic upstream hands it a start address, a byte count and a direction. For a write it pulls bytes from a byte stream. For a read it returns bytes on a valid-qualified output.

Every request is cut into pieces of at most `CHUNK_MAX` bytes, and the address advances by each piece's length. A write piece goes out in three steps. First comes a one-byte enable transaction. Next, a framed write transaction carries the piece. After that, the block polls the device status until the busy bit clears. The wait between polls is one millisecond, measured as `CYC_PER_MS` clock cycles. If the device is still busy after `POLL_MAX` attempts, the request is aborted and flagged as timed out.

The SPI shifter sits outside this block and is reached through a byte handshake. The sequencer raises a start strobe with a byte to send and holds chip select, and the shifter answers with a done strobe and the byte it received.

Top module: `eeprom_spi_seq`

## Requirements
- R1: A request on `req_valid_i` is taken only while `req_ready_o` is 1, which holds only in the idle state. A request strobed while busy is ignored: it adds no transaction and no data.
- R2: A request with length 0 raises `done_o` in the cycle after acceptance, with no SPI activity.
- R3: A request is split into pieces of min(remaining, 16) bytes. Each piece is addressed at the start address plus the bytes already handled.
- R4: Each write piece starts with a one-byte transaction carrying 0x06, after which chip select is released. A second transaction then carries 0x02, the address high byte, the address low byte and the data bytes, all under one chip-select assertion.
- R5: After each write transaction, status polls are sent. Each poll is a two-byte transaction of 0x05 followed by a 0x00 dummy byte. Polling ends at the first poll whose second received byte has bit 0 equal to 0.
- R6: Between two consecutive status polls, chip select stays released for at least `CYC_PER_MS` cycles.
- R7: If `POLL_MAX` polls in a row all report busy, the remaining pieces are dropped, `done_o` pulses and `timeout_o` rises with it. `timeout_o` then holds until the next request is accepted.
- R8: A read piece is one transaction: 0x03, the address high byte, the address low byte, then one 0x00 byte per data byte. Each byte received from position 3 onward appears on `rd_data_o` with `rd_valid_o` for one cycle, in order.
- R9: `done_o` is a one-cycle pulse at the end of each request, and `req_ready_o` is 1 in the next cycle.
- R10: `spi_start_o` is raised only while `spi_cs_o` (active high) is 1, and only once per byte. No new start comes until `spi_done_i` answers. `wr_data_pop_o` pulses together with the start of each write data byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request strobe |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Start address |
| req_len_i | input | LEN_W | Byte count |
| req_ready_o | output | 1 | Idle, request can be taken |
| wr_data_i | input | 8 | Current write byte of the stream |
| wr_data_pop_o | output | 1 | Write byte consumed |
| rd_data_o | output | 8 | Read byte |
| rd_valid_o | output | 1 | Read byte valid |
| done_o | output | 1 | Request finished (pulse) |
| timeout_o | output | 1 | Busy polling timed out |
| spi_cs_o | output | 1 | Chip select, active high |
| spi_start_o | output | 1 | Start one byte transfer |
| spi_tx_o | output | 8 | Byte to shift out |
| spi_rx_i | input | 8 | Byte shifted in |
| spi_done_i | input | 1 | Byte transfer finished |

## Verification
A corrupted byte index or phase shows up within the same transaction. It appears as a frame with the wrong length, the wrong opcode or the wrong address bytes, and the frame monitor catches it at the chip-select fall. A bad piece counter or address accumulator shows up one piece later, as a missing, extra or misaddressed frame, or as read data that does not match the reference image. A faulty poll counter or delay counter changes how many status frames appear, how wide the gaps between them are, or when `timeout_o` rises. All of these show at the end of the request that contains the fault.

// File: rtl/eeprom_seq_pkg.sv
package eeprom_seq_pkg;
  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_WRITE = 8'h02;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CHUNK, ST_SEND, ST_WAIT, ST_GAP, ST_DELAY, ST_DONE
  } seq_state_e;

  typedef enum logic [1:0] {
    PH_WREN, PH_WRITE, PH_READ, PH_POLL
  } seq_phase_e;
endpackage

// File: rtl/eeprom_chunk_ctl.sv
module eeprom_chunk_ctl #(
  parameter int ADDR_W    = 16,
  parameter int LEN_W     = 16,
  parameter int CHUNK_MAX = 16,
  localparam int CLEN_W   = $clog2(CHUNK_MAX + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              advance_i,
  output logic [ADDR_W-1:0] cur_addr_o,
  output logic [CLEN_W-1:0] chunk_len_o,
  output logic              rem_zero_o
);
  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  rem_q;

  always_comb begin
    if (rem_q > LEN_W'(CHUNK_MAX)) chunk_len_o = CLEN_W'(CHUNK_MAX);
    else                           chunk_len_o = rem_q[CLEN_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      rem_q  <= '0;
    end else if (load_i) begin
      addr_q <= addr_i;
      rem_q  <= len_i;
    end else if (advance_i) begin
      addr_q <= addr_q + ADDR_W'(chunk_len_o);
      rem_q  <= rem_q - LEN_W'(chunk_len_o);
    end
  end

  assign cur_addr_o = addr_q;
  assign rem_zero_o = (rem_q == '0);
endmodule

// File: rtl/eeprom_poll_timer.sv
module eeprom_poll_timer #(
  parameter int CYC_PER_MS = 50000,
  parameter int POLL_MAX   = 1000,
  localparam int DLY_W     = $clog2(CYC_PER_MS + 1),
  localparam int ATT_W     = $clog2(POLL_MAX + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic count_i,
  input  logic delay_start_i,
  output logic last_attempt_o,
  output logic delay_done_o
);
  logic [ATT_W-1:0] att_q;
  logic [DLY_W-1:0] dly_q;
  logic             run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      att_q <= '0;
    else if (clear_i) att_q <= '0;
    else if (count_i) att_q <= att_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      dly_q <= '0;
    end else if (delay_start_i) begin
      run_q <= 1'b1;
      dly_q <= DLY_W'(CYC_PER_MS - 1);
    end else if (run_q) begin
      if (dly_q == '0) run_q <= 1'b0;
      else             dly_q <= dly_q - 1'b1;
    end
  end

  // attempt under evaluation is the last one allowed
  assign last_attempt_o = (att_q == ATT_W'(POLL_MAX - 1));
  assign delay_done_o   = run_q && (dly_q == '0);
endmodule

// File: rtl/eeprom_spi_seq.sv
module eeprom_spi_seq
  import eeprom_seq_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int LEN_W      = 16,
  parameter int CHUNK_MAX  = 16,
  parameter int CYC_PER_MS = 50000,
  parameter int POLL_MAX   = 1000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [LEN_W-1:0]  req_len_i,
  output logic              req_ready_o,
  input  logic [7:0]        wr_data_i,
  output logic              wr_data_pop_o,
  output logic [7:0]        rd_data_o,
  output logic              rd_valid_o,
  output logic              done_o,
  output logic              timeout_o,
  output logic              spi_cs_o,
  output logic              spi_start_o,
  output logic [7:0]        spi_tx_o,
  input  logic [7:0]        spi_rx_i,
  input  logic              spi_done_i
);
  localparam int CLEN_W = $clog2(CHUNK_MAX + 1);
  localparam int IDX_W  = $clog2(CHUNK_MAX + 3);

  seq_state_e        state_q;
  seq_phase_e        phase_q;
  logic [IDX_W-1:0]  idx_q, last_idx;
  logic              is_write_q, busy_q, timeout_q;
  logic              rd_valid_q;
  logic [7:0]        rd_data_q;

  logic              load, advance;
  logic [ADDR_W-1:0] cur_addr;
  logic [CLEN_W-1:0] chunk_len;
  logic              rem_zero;
  logic              t_clear, t_count, t_start, last_attempt, delay_done;

  eeprom_chunk_ctl #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .CHUNK_MAX(CHUNK_MAX)
  ) u_chunk (
    .clk_i, .rst_ni,
    .load_i(load), .addr_i(req_addr_i), .len_i(req_len_i),
    .advance_i(advance), .cur_addr_o(cur_addr),
    .chunk_len_o(chunk_len), .rem_zero_o(rem_zero)
  );

  eeprom_poll_timer #(
    .CYC_PER_MS(CYC_PER_MS), .POLL_MAX(POLL_MAX)
  ) u_timer (
    .clk_i, .rst_ni,
    .clear_i(t_clear), .count_i(t_count), .delay_start_i(t_start),
    .last_attempt_o(last_attempt), .delay_done_o(delay_done)
  );

  always_comb begin
    unique case (phase_q)
      PH_WREN: last_idx = '0;
      PH_POLL: last_idx = IDX_W'(1);
      default: last_idx = IDX_W'(chunk_len) + IDX_W'(2);
    endcase
  end

  // byte selection by position in the frame
  always_comb begin
    spi_tx_o = 8'h00;
    if (idx_q == '0) begin
      unique case (phase_q)
        PH_WREN:  spi_tx_o = OP_WREN;
        PH_WRITE: spi_tx_o = OP_WRITE;
        PH_READ:  spi_tx_o = OP_READ;
        default:  spi_tx_o = OP_RDSR;
      endcase
    end else if (phase_q != PH_POLL) begin
      if (idx_q == IDX_W'(1))      spi_tx_o = cur_addr[ADDR_W-1 -: 8];
      else if (idx_q == IDX_W'(2)) spi_tx_o = cur_addr[7:0];
      else if (phase_q == PH_WRITE) spi_tx_o = wr_data_i;
    end
  end

  wire idle     = (state_q == ST_IDLE);
  wire accept   = idle && req_valid_i;
  wire in_gap   = (state_q == ST_GAP);
  wire poll_end = in_gap && (phase_q == PH_POLL);

  assign load    = accept;
  assign advance = in_gap && ((phase_q == PH_READ) || (phase_q == PH_POLL && !busy_q));
  assign t_clear = in_gap && (phase_q == PH_WRITE);
  assign t_count = poll_end && busy_q && !last_attempt;
  assign t_start = t_count;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      phase_q    <= PH_READ;
      idx_q      <= '0;
      is_write_q <= 1'b0;
      busy_q     <= 1'b0;
      timeout_q  <= 1'b0;
      rd_valid_q <= 1'b0;
      rd_data_q  <= 8'h00;
    end else begin
      rd_valid_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (req_valid_i) begin
          timeout_q  <= 1'b0;
          is_write_q <= req_write_i;
          state_q    <= (req_len_i == '0) ? ST_DONE : ST_CHUNK;
        end
        ST_CHUNK: begin
          idx_q <= '0;
          if (rem_zero) state_q <= ST_DONE;
          else begin
            phase_q <= is_write_q ? PH_WREN : PH_READ;
            state_q <= ST_SEND;
          end
        end
        ST_SEND: state_q <= ST_WAIT;
        ST_WAIT: if (spi_done_i) begin
          if (phase_q == PH_POLL && idx_q == IDX_W'(1)) busy_q <= spi_rx_i[0];
          if (phase_q == PH_READ && idx_q > IDX_W'(2)) begin
            rd_valid_q <= 1'b1;
            rd_data_q  <= spi_rx_i;
          end
          if (idx_q == last_idx) state_q <= ST_GAP;
          else begin
            idx_q   <= idx_q + 1'b1;
            state_q <= ST_SEND;
          end
        end
        ST_GAP: begin
          idx_q <= '0;
          unique case (phase_q)
            PH_WREN:  begin phase_q <= PH_WRITE; state_q <= ST_SEND; end
            PH_WRITE: begin phase_q <= PH_POLL;  state_q <= ST_SEND; end
            PH_READ:  state_q <= ST_CHUNK;
            default: begin
              if (!busy_q)          state_q <= ST_CHUNK;
              else if (last_attempt) begin
                timeout_q <= 1'b1;
                state_q   <= ST_DONE;
              end else               state_q <= ST_DELAY;
            end
          endcase
        end
        ST_DELAY: if (delay_done) state_q <= ST_SEND;
        ST_DONE:  state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o   = idle;
  assign spi_cs_o      = (state_q == ST_SEND) || (state_q == ST_WAIT);
  assign spi_start_o   = (state_q == ST_SEND);
  assign wr_data_pop_o = spi_start_o && (phase_q == PH_WRITE) && (idx_q > IDX_W'(2));
  assign rd_valid_o    = rd_valid_q;
  assign rd_data_o     = rd_data_q;
  assign done_o        = (state_q == ST_DONE);
  assign timeout_o     = timeout_q;
endmodule

// File: rtl/eeprom_spi_seq_chk.sv
module eeprom_spi_seq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic req_ready_o,
  input logic wr_data_pop_o,
  input logic rd_valid_o,
  input logic done_o,
  input logic timeout_o,
  input logic spi_cs_o,
  input logic spi_start_o,
  input logic spi_done_i
);
  a_r10_start_under_cs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spi_start_o |-> spi_cs_o);
  a_r10_one_in_flight: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spi_start_o |=> !spi_start_o);
  a_r10_pop_with_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_data_pop_o |-> spi_start_o);
  a_r9_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r9_ready_after_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> req_ready_o);
  a_r1_busy_no_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spi_cs_o |-> !req_ready_o);
  a_r7_timeout_with_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(timeout_o) |-> done_o);
  a_r8_rd_after_byte: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> $past(spi_done_i));
endmodule

bind eeprom_spi_seq eeprom_spi_seq_chk u_chk (
  .clk_i, .rst_ni, .req_ready_o, .wr_data_pop_o, .rd_valid_o,
  .done_o, .timeout_o, .spi_cs_o, .spi_start_o, .spi_done_i
);

// File: tb/eeprom_spi_seq_tb.sv
module eeprom_spi_seq_tb;
  localparam int CYC   = 20;
  localparam int PMAX  = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [15:0] req_addr = '0, req_len = '0;
  logic        req_ready, wr_pop, rd_valid, done, timeout;
  logic [7:0]  wr_data, rd_data, spi_tx, spi_rx;
  logic        spi_cs, spi_start, spi_done;

  eeprom_spi_seq #(.CYC_PER_MS(CYC), .POLL_MAX(PMAX)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_write_i(req_write),
    .req_addr_i(req_addr), .req_len_i(req_len), .req_ready_o(req_ready),
    .wr_data_i(wr_data), .wr_data_pop_o(wr_pop),
    .rd_data_o(rd_data), .rd_valid_o(rd_valid),
    .done_o(done), .timeout_o(timeout),
    .spi_cs_o(spi_cs), .spi_start_o(spi_start), .spi_tx_o(spi_tx),
    .spi_rx_i(spi_rx), .spi_done_i(spi_done)
  );

  int n_tests = 0, n_fail = 0;
  bit finished = 1'b0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int k);
    return 8'(k * 37 + 11);
  endfunction

  // write byte stream
  int pop_cnt = 0;
  assign wr_data = pat(pop_cnt);
  always @(posedge clk) if (wr_pop) pop_cnt <= pop_cnt + 1;

  // EEPROM device model
  logic [7:0]  mem [0:1023];
  int          busy_cfg = 2;
  int          busy_cnt = 0;
  bit          wel = 1'b0;
  int          pos = 0, cnt = 0;
  logic [7:0]  cur_tx, d_op, a_hi, a_lo;
  bit          cs_q = 1'b0, fr_end = 1'b0;
  logic [7:0]  fr_op;
  logic [15:0] fr_addr;
  int          fr_len, fr_start, fr_stop, st_start;

  function automatic logic [7:0] resp(input int p);
    if (d_op == 8'h05 && p == 1) return {7'd0, busy_cnt != 0};
    if (d_op == 8'h03 && p >= 3) return mem[10'({a_hi, a_lo} + 16'(p - 3))];
    return 8'hA5;
  endfunction

  always @(posedge clk) begin
    spi_done <= 1'b0;
    fr_end   <= 1'b0;
    cs_q     <= spi_cs;
    if (spi_cs && !cs_q) st_start <= cyc;
    if (cs_q && !spi_cs) begin
      fr_end  <= 1'b1;
      fr_op   <= d_op;
      fr_addr <= {a_hi, a_lo};
      fr_len  <= pos;
      fr_start <= st_start;
      fr_stop <= cyc;
      pos     <= 0;
      if (d_op == 8'h02) begin busy_cnt <= busy_cfg; wel <= 1'b0; end
      if (d_op == 8'h05 && busy_cnt != 0) busy_cnt <= busy_cnt - 1;
    end
    if (spi_start) begin
      cur_tx <= spi_tx;
      cnt    <= 3;
      spi_rx <= resp(pos);
    end else if (cnt != 0) begin
      cnt <= cnt - 1;
      if (cnt == 1) begin
        spi_done <= 1'b1;
        pos <= pos + 1;
        if (pos == 0) begin
          d_op <= cur_tx;
          if (cur_tx == 8'h06) wel <= 1'b1;
        end
        if (pos == 1) a_hi <= cur_tx;
        if (pos == 2) a_lo <= cur_tx;
        if (pos >= 3 && d_op == 8'h02) begin
          mem[10'({a_hi, a_lo} + 16'(pos - 3))] <= cur_tx;
          check(wel, "R4", "write without enable", 0, 1);
        end
        if (pos == 1 && d_op == 8'h05) check(cur_tx == 8'h00, "R5", "dummy byte", cur_tx, 0);
      end
    end
  end

  // scoreboard: expected frames {op, addr, len} and read bytes
  logic [31:0] exp_q [$];
  logic [7:0]  rd_exp_q [$];
  logic [7:0]  ref_mem [0:1023];
  bit          prev_stat = 1'b0;
  int          prev_stop = 0;

  always @(negedge clk) begin
    if (fr_end) begin
      if (exp_q.size() == 0) begin
        check(0, "R1", "unexpected frame op", fr_op, 0);
      end else begin
        logic [31:0] e;
        e = exp_q.pop_front();
        check(fr_op == e[31:24], "R4", "frame opcode", fr_op, e[31:24]);
        if (e[31:24] == 8'h02 || e[31:24] == 8'h03)
          check(fr_addr == e[23:8], "R3", "frame address", fr_addr, e[23:8]);
        check(fr_len == int'(e[7:0]), "R3", "frame length", fr_len, e[7:0]);
      end
      if (fr_op == 8'h05 && prev_stat)
        check(fr_start - prev_stop >= CYC, "R6", "poll gap", fr_start - prev_stop, CYC);
      prev_stat = (fr_op == 8'h05);
      prev_stop = fr_stop;
    end
    if (rd_valid) begin
      if (rd_exp_q.size() == 0) check(0, "R8", "unexpected read byte", rd_data, 0);
      else begin
        logic [7:0] e;
        e = rd_exp_q.pop_front();
        check(rd_data == e, "R8", "read byte", rd_data, e);
      end
    end
  end

  task automatic run_req(input bit wr, input logic [15:0] a, input int n, input bit exp_to);
    int rem, c, k, polls;
    logic [15:0] ca;
    bit first_done, got;
    rem = n; ca = a; k = 0;
    while (rem > 0) begin
      c = (rem > 16) ? 16 : rem;
      if (wr) begin
        exp_q.push_back({8'h06, 16'h0, 8'd1});
        exp_q.push_back({8'h02, ca, 8'(3 + c)});
        for (int i = 0; i < c; i++) begin
          ref_mem[10'(ca + 16'(i))] = pat(pop_cnt + k);
          k++;
        end
        polls = (busy_cfg >= PMAX) ? PMAX : busy_cfg + 1;
        for (int i = 0; i < polls; i++) exp_q.push_back({8'h05, 16'h0, 8'd2});
        if (busy_cfg >= PMAX) break;
      end else begin
        exp_q.push_back({8'h03, ca, 8'(3 + c)});
        for (int i = 0; i < c; i++) rd_exp_q.push_back(ref_mem[10'(ca + 16'(i))]);
      end
      ca = ca + 16'(c);
      rem -= c;
    end
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_len = 16'(n);
    @(negedge clk);
    req_valid = 1'b0;
    first_done = done;
    check(timeout == 1'b0, "R7", "timeout cleared on accept", timeout, 0);
    if (n == 0) begin
      check(first_done, "R2", "zero length done", first_done, 1);
      check(!spi_cs, "R2", "zero length no cs", spi_cs, 0);
    end else
      check(!req_ready, "R1", "busy after accept", req_ready, 0);
    got = first_done;
    for (int t = 0; t < 20000 && !got; t++) begin
      @(negedge clk);
      got = done;
    end
    check(got, "R9", "done seen", got, 1);
    check(timeout == exp_to, "R7", "timeout flag", timeout, exp_to);
    @(negedge clk);
    check(!done, "R9", "done one cycle", done, 0);
    check(req_ready, "R9", "ready after done", req_ready, 1);
    check(timeout == exp_to, "R7", "timeout held", timeout, exp_to);
    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R3", "frames outstanding", exp_q.size(), 0);
    check(rd_exp_q.size() == 0, "R8", "read bytes outstanding", rd_exp_q.size(), 0);
    prev_stat = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) begin mem[i] = 8'(i ^ 8'h5A); ref_mem[i] = 8'(i ^ 8'h5A); end
    repeat (3) @(negedge clk);
    check(req_ready && !done && !timeout && !spi_cs && !spi_start,
          "R1", "reset state", {req_ready, done, timeout, spi_cs}, 4'b1000);
    rst_n = 1'b1;
    @(negedge clk);
    run_req(1'b1, 16'h0010, 5, 1'b0);      // R4 R5 single write piece
    run_req(1'b0, 16'h0010, 5, 1'b0);      // R8 read back
    run_req(1'b1, 16'h0100, 37, 1'b0);     // R3 split 16/16/5
    run_req(1'b0, 16'h0100, 37, 1'b0);     // R3 R8
    run_req(1'b0, 16'h03F8, 6, 1'b0);      // R8 untouched contents
    run_req(1'b1, 16'h0040, 0, 1'b0);      // R2
    busy_cfg = 0;
    run_req(1'b1, 16'h0080, 16, 1'b0);     // R5 first poll not busy
    busy_cfg = 100;
    run_req(1'b1, 16'h0200, 20, 1'b1);     // R7 timeout aborts second piece
    busy_cfg = 0;
    run_req(1'b0, 16'h0200, 20, 1'b0);     // R7 cleared; R3 aborted piece untouched
    busy_cfg = 3;
    fork
      run_req(1'b0, 16'h0100, 20, 1'b0);
      begin
        repeat (30) @(negedge clk);
        check(!req_ready, "R1", "ready low while busy", req_ready, 0);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 16'h0300; req_len = 16'd5;
        @(negedge clk);
        req_valid = 1'b0;
      end
    join
    check(pop_cnt == 5 + 37 + 16 + 16, "R10", "write bytes consumed", pop_cnt, 74);
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual expired expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule